// File: doc/BRIEF.md
# Video RAM Block Copy Engine

This block moves data from anywhere in the 16-bit address space into the 8 KiB video RAM window at 0x8000-0x9FFF. It works in units of 16 bytes. Software loads a 16-bit source and a 16-bit destination through four byte registers. A write to a fifth control byte then starts the copy. Bit 7 of that byte picks the mode, and bits 6:0 give the number of units minus one.

In general mode every unit is copied back to back while the processor is held off through `cpu_stall`. In blanking mode the engine arms itself and copies one unit for each rising edge of the horizontal-blank input. This lets the processor keep running between lines. Reading the control byte shows the remaining unit count and whether a transfer is still live.

The engine is a bus master with a single address bus. Each byte takes two cycles. In the first it issues a read strobe with the source address. In the second it issues a write strobe with the destination address and forwards the read data, which the memory returns one cycle after the read strobe.

Top module: `vram_dma`

## Requirements
- R1: After reset the control byte reads 0xFF, `mem_rd`, `mem_wr` and `cpu_stall` are low.
- R2: Register select 0/1 are source high/low, 2/3 destination high/low, 4 control. Only select 4 reads back, and every other select reads 0xFF. The source address is {high,low} with bits 3:0 cleared. The destination is 0x8000 OR ({high,low} AND 0x1FF0).
- R3: A control write with bit 7 = 0 starts a general copy of (bits[6:0]+1)*16 bytes. Each byte is one read cycle (`mem_rd`, address = source) followed by one write cycle (`mem_wr`, address = destination, `mem_wdata` = `mem_rdata`). Bytes follow back to back. Source and destination each advance by one per byte.
- R4: `cpu_stall` is high on exactly the read and write cycles of the copy, which is 2 cycles per byte. It is low while idle and while a blanking transfer waits.
- R5: When a general copy ends, the control byte reads 0xFF.
- R6: A start write whose source lies in 0x8000-0x9FFF is ignored. No strobe is issued and the control byte keeps reading 0xFF.
- R7: A control write with bit 7 = 1 starts a blanking transfer that issues nothing until `hblank` rises. Each rising edge copies exactly one 16-byte unit (32 cycles). Holding `hblank` high does not trigger a second unit.
- R8: While a blanking transfer is live the control byte reads {0, units left minus one}, and this value drops by one after each unit. After the last unit it reads 0xFF.
- R9: A control write with bit 7 = 0 while a blanking transfer waits stops the transfer. The control byte then reads {1, unchanged count}, and later `hblank` edges copy nothing.
- R10: The destination wraps from 0x9FFF to 0x8000 inside a copy, while the source keeps counting linearly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (control status on select 4) |
| hblank | input | 1 | Horizontal-blank level; rising edge paces blanking mode |
| mem_addr | output | 16 | Master address (source on reads, destination on writes) |
| mem_rd | output | 1 | Master read strobe |
| mem_wr | output | 1 | Master write strobe |
| mem_wdata | output | 8 | Master write data |
| mem_rdata | input | 8 | Master read data, valid the cycle after `mem_rd` |
| cpu_stall | output | 1 | Processor hold-off while bytes are moving |

## Verification
The bench starts from unaligned source and destination register values. An engine that failed to clear the low bits, or to force the destination into the video window, would put the wrong addresses on the bus and the scoreboard would flag every byte. One copy starts at 0x9FF0 and runs across the top of the window. A design without the wrap would write to 0xA000 and above. The blanking tests hold `hblank` high for longer than a unit, so a level-triggered engine would copy extra units and drain the count early. A stop command is also issued mid-transfer, and an engine that ignored it would keep copying on the next edge. A start with a source inside video RAM must leave the bus silent, and the stall counter catches any off-by-one in the 2-cycle byte rhythm.

// File: rtl/vram_dma_pkg.sv
package vram_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_state_t;

  localparam int unsigned SEL_SRC_HI = 0;
  localparam int unsigned SEL_SRC_LO = 1;
  localparam int unsigned SEL_DST_HI = 2;
  localparam int unsigned SEL_DST_LO = 3;
  localparam int unsigned SEL_CTRL   = 4;

endpackage

// File: rtl/vram_dma_regs.sv
module vram_dma_regs
  import vram_dma_pkg::*;
#(
  parameter int AW     = 16,
  parameter int OFF_W  = 13,
  parameter int RSEL_W = 3,
  parameter int BW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [BW-1:0]     reg_wdata,
  input  logic [BW-1:0]     status,
  output logic [AW-1:0]     src_base,
  output logic [AW-1:0]     dst_base,
  output logic              ctrl_wr,
  output logic [BW-1:0]     ctrl_val,
  output logic              src_ok,
  output logic [BW-1:0]     reg_rdata
);
  localparam int TAG_W = AW - OFF_W;
  localparam logic [TAG_W-1:0] VRAM_TAG = {1'b1, {(TAG_W-1){1'b0}}};

  logic [BW-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RSEL_W'(SEL_SRC_HI): src_hi_q <= reg_wdata;
        RSEL_W'(SEL_SRC_LO): src_lo_q <= reg_wdata;
        RSEL_W'(SEL_DST_HI): dst_hi_q <= reg_wdata;
        RSEL_W'(SEL_DST_LO): dst_lo_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign src_base  = {src_hi_q, src_lo_q};
  assign dst_base  = {dst_hi_q, dst_lo_q};
  assign ctrl_wr   = reg_we && (reg_addr == RSEL_W'(SEL_CTRL));
  assign ctrl_val  = reg_wdata;
  assign src_ok    = (src_base[AW-1:OFF_W] != VRAM_TAG);
  assign reg_rdata = (reg_addr == RSEL_W'(SEL_CTRL)) ? status : '1;

endmodule

// File: rtl/vram_dma_addr.sv
module vram_dma_addr #(
  parameter int AW      = 16,
  parameter int OFF_W   = 13,
  parameter int UNIT_LG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_addr
);
  localparam int TAG_W = AW - OFF_W;
  localparam logic [TAG_W-1:0] VRAM_TAG = {1'b1, {(TAG_W-1){1'b0}}};

  logic [AW-1:0]    src_q;
  logic [OFF_W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (load) begin
      src_q <= {src_base[AW-1:UNIT_LG], {UNIT_LG{1'b0}}};
      dst_q <= {dst_base[OFF_W-1:UNIT_LG], {UNIT_LG{1'b0}}};
    end else if (step) begin
      src_q <= src_q + 1'b1;
      dst_q <= dst_q + 1'b1;
    end
  end

  assign src_ptr  = src_q;
  assign dst_addr = {VRAM_TAG, dst_q};

endmodule

// File: rtl/vram_dma_seq.sv
module vram_dma_seq
  import vram_dma_pkg::*;
#(
  parameter int UNIT_LG = 4,
  parameter int LEN_W   = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctrl_wr,
  input  logic [LEN_W:0] ctrl_val,
  input  logic           src_ok,
  input  logic           hblank,
  output logic           load,
  output logic           step,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           stall,
  output logic [LEN_W:0] status
);
  seq_state_t         state_q;
  logic               active_q;
  logic               blank_q;
  logic [LEN_W-1:0]   len_q;
  logic [UNIT_LG-1:0] byte_q;
  logic               hb_q;

  logic hb_rise, mode_bit, stop_req, can_start, last_byte;

  assign hb_rise   = hblank && !hb_q;
  assign mode_bit  = ctrl_val[LEN_W];
  assign stop_req  = ctrl_wr && active_q && blank_q && !mode_bit;
  assign can_start = ctrl_wr && src_ok && !stop_req &&
                     (state_q == ST_IDLE || state_q == ST_WAIT);
  assign last_byte = (byte_q == {UNIT_LG{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
      blank_q  <= 1'b0;
      len_q    <= '1;
      byte_q   <= '0;
      hb_q     <= 1'b0;
    end else begin
      hb_q <= hblank;
      if (stop_req) begin
        active_q <= 1'b0;
        state_q  <= ST_IDLE;
      end else if (can_start) begin
        active_q <= 1'b1;
        blank_q  <= mode_bit;
        len_q    <= ctrl_val[LEN_W-1:0];
        byte_q   <= '0;
        state_q  <= mode_bit ? ST_WAIT : ST_RD;
      end else begin
        case (state_q)
          ST_WAIT: if (hb_rise) state_q <= ST_RD;
          ST_RD:   state_q <= ST_WR;
          ST_WR: begin
            byte_q <= byte_q + 1'b1;
            if (last_byte) begin
              len_q <= len_q - 1'b1;
              if (len_q == '0) begin
                active_q <= 1'b0;
                state_q  <= ST_IDLE;
              end else begin
                state_q <= blank_q ? ST_WAIT : ST_RD;
              end
            end else begin
              state_q <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign load   = can_start;
  assign step   = (state_q == ST_WR);
  assign mem_rd = (state_q == ST_RD);
  assign mem_wr = (state_q == ST_WR);
  assign stall  = (state_q == ST_RD) || (state_q == ST_WR);
  assign status = {!active_q, len_q};

endmodule

// File: rtl/vram_dma.sv
module vram_dma #(
  parameter int AW      = 16,
  parameter int OFF_W   = 13,
  parameter int UNIT_LG = 4,
  parameter int LEN_W   = 7,
  parameter int RSEL_W  = 3,
  parameter int DW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [LEN_W:0]    reg_wdata,
  output logic [LEN_W:0]    reg_rdata,
  input  logic              hblank,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              cpu_stall
);
  localparam int BW = LEN_W + 1;

  logic [AW-1:0] src_base, dst_base, src_ptr, dst_addr;
  logic          ctrl_wr, src_ok, load, step;
  logic [BW-1:0] ctrl_val, status;

  vram_dma_regs #(.AW(AW), .OFF_W(OFF_W), .RSEL_W(RSEL_W), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .src_base(src_base),
    .dst_base(dst_base), .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val),
    .src_ok(src_ok), .reg_rdata(reg_rdata)
  );

  vram_dma_seq #(.UNIT_LG(UNIT_LG), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val),
    .src_ok(src_ok), .hblank(hblank), .load(load), .step(step),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .stall(cpu_stall), .status(status)
  );

  vram_dma_addr #(.AW(AW), .OFF_W(OFF_W), .UNIT_LG(UNIT_LG)) u_addr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .src_base(src_base), .dst_base(dst_base),
    .src_ptr(src_ptr), .dst_addr(dst_addr)
  );

  assign mem_addr  = mem_wr ? dst_addr : src_ptr;
  assign mem_wdata = mem_rdata;

endmodule

// File: rtl/vram_dma_chk.sv
module vram_dma_chk #(
  parameter int AW    = 16,
  parameter int OFF_W = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          cpu_stall
);
  localparam int TAG_W = AW - OFF_W;
  localparam logic [TAG_W-1:0] VRAM_TAG = {1'b1, {(TAG_W-1){1'b0}}};

  // R1: first cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_rd && !mem_wr && !cpu_stall));

  // R3: never read and write in the same cycle
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R3: every write is preceded by its read
  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));

  // R3: consecutive reads in one burst step the source by one
  p_src_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_wr) && $past(mem_rd, 2)) |-> (mem_addr == $past(mem_addr, 2) + 1'b1));

  // R4: bus activity only while the processor is held
  p_stall_cover_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> cpu_stall);

  // R10: writes always land in the video window
  p_dst_window_r10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr[AW-1:OFF_W] == VRAM_TAG));

endmodule

bind vram_dma vram_dma_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .cpu_stall(cpu_stall)
);

// File: tb/vram_dma_test.sv
`timescale 1ns/1ps
module vram_dma_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, cpu_stall;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;

  int errors = 0;
  int checks = 0;
  int stall_cnt = 0;
  int strobe_cnt = 0;
  logic [15:0] rdq[$];
  logic [23:0] wrq[$];

  always #5 clk = ~clk;

  vram_dma uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_stall(cpu_stall)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: synchronous read, data one cycle after the read strobe
  always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cpu_stall) stall_cnt++;
      if (mem_rd || mem_wr) strobe_cnt++;
      if (mem_rd) begin
        if (rdq.size() == 0) chk(1'b0, "R6 unexpected read", mem_addr, 0);
        else begin
          logic [15:0] e;
          e = rdq.pop_front();
          chk(mem_addr == e, "R2/R3 read address", mem_addr, e);
        end
      end
      if (mem_wr) begin
        if (wrq.size() == 0) chk(1'b0, "R6 unexpected write", mem_addr, 0);
        else begin
          logic [23:0] w;
          w = wrq.pop_front();
          chk(mem_addr == w[23:8], "R2/R10 write address", mem_addr, w[23:8]);
          chk(mem_wdata == w[7:0], "R3 write data", mem_wdata, w[7:0]);
        end
      end
    end
  end

  task automatic push_copy(input logic [15:0] src, input logic [15:0] dst, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] s, d;
      s = src + 16'(i);
      d = 16'h8000 | ((dst + 16'(i)) & 16'h1FFF);
      rdq.push_back(s);
      wrq.push_back({d, pat(s)});
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_status(input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = 3'd4;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic set_addrs(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
  endtask

  task automatic wait_idle();
    while (cpu_stall) @(negedge clk);
  endtask

  task automatic pulse_hb();
    @(negedge clk); hblank = 1'b1;
    repeat (45) @(negedge clk);
    hblank = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    stall_cnt = 0; strobe_cnt = 0;
  endtask

  task automatic chk_drained(input string req);
    chk(rdq.size() == 0 && wrq.size() == 0, req, rdq.size() + wrq.size(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    #1;
    chk(!mem_rd && !mem_wr && !cpu_stall, "R1 strobes after reset", {mem_rd, mem_wr, cpu_stall}, 0);
    chk_status(8'hFF, "R1 status after reset");
    @(negedge clk); reg_addr = 3'd0; #1;
    chk(reg_rdata == 8'hFF, "R2 address register reads 0xFF", reg_rdata, 8'hFF);

    // R2/R3/R4/R5 general copy with unaligned register values
    set_addrs(16'h1234, 16'h9AB7);
    push_copy(16'h1230, 16'h9AB0, 32);
    clear_counts();
    wr_reg(3'd4, 8'h01);
    wait_idle();
    chk(stall_cnt == 64, "R4 stall cycles general", stall_cnt, 64);
    chk(strobe_cnt == 64, "R3 strobe count general", strobe_cnt, 64);
    chk_drained("R3 all bytes copied");
    chk_status(8'hFF, "R5 status after general copy");

    // R10 destination wrap
    set_addrs(16'hC000, 16'h1FF0);
    push_copy(16'hC000, 16'h9FF0, 32);
    clear_counts();
    wr_reg(3'd4, 8'h01);
    wait_idle();
    chk_drained("R10 wrap copy complete");
    chk(stall_cnt == 64, "R10 stall cycles wrap copy", stall_cnt, 64);

    // R6 rejected source
    set_addrs(16'h8800, 16'h8000);
    clear_counts();
    wr_reg(3'd4, 8'h00);
    repeat (40) @(negedge clk);
    chk(strobe_cnt == 0, "R6 no strobes for rejected source", strobe_cnt, 0);
    chk(stall_cnt == 0, "R6 no stall for rejected source", stall_cnt, 0);
    chk_status(8'hFF, "R6 status unchanged");

    // R7/R8 blanking mode, three units
    set_addrs(16'h4000, 16'h8100);
    push_copy(16'h4000, 16'h8100, 48);
    clear_counts();
    wr_reg(3'd4, 8'h82);
    chk_status(8'h02, "R8 status after blank start");
    repeat (10) @(negedge clk);
    chk(strobe_cnt == 0, "R7 idle until hblank", strobe_cnt, 0);
    pulse_hb();
    chk(strobe_cnt == 32, "R7 one unit per edge (held level)", strobe_cnt, 32);
    chk(stall_cnt == 32, "R4 stall cycles per unit", stall_cnt, 32);
    chk_status(8'h01, "R8 count after first unit");
    pulse_hb();
    chk_status(8'h00, "R8 count after second unit");
    pulse_hb();
    chk_status(8'hFF, "R8 status after last unit");
    chk(strobe_cnt == 96, "R7 strobe total for three units", strobe_cnt, 96);
    chk_drained("R7 blank bytes copied");

    // R9 stop while waiting
    set_addrs(16'h2000, 16'h8200);
    push_copy(16'h2000, 16'h8200, 16);
    clear_counts();
    wr_reg(3'd4, 8'h85);
    pulse_hb();
    chk_status(8'h04, "R8 count after one unit of six");
    wr_reg(3'd4, 8'h00);
    chk_status(8'h84, "R9 status after stop");
    clear_counts();
    pulse_hb();
    chk(strobe_cnt == 0, "R9 no copy after stop", strobe_cnt, 0);
    chk_status(8'h84, "R9 status stable after stop");
    chk_drained("R9 first unit copied");

    summary();
    $finish;
  end
endmodule